// File: doc/BRIEF.md
# Load/Store Multiple Micro-op Sequencer

This block breaks a block-transfer instruction into a stream of micro-operations. It issues one micro-op per handshake on its output side. When idle it accepts one 32-bit instruction word. It decodes the addressing mode and the 16-bit register list from that word. It then emits, in order:

- a micro-op that copies the base register;
- one load or store micro-op for each selected register, carrying the register number and a byte offset from the base;
- an add or subtract micro-op that updates the base register, but only when writeback is requested.

The field positions in the instruction are fixed:

- condition in bits 31:28;
- mode in bits 24:20, ordered as pre-index, up, user-bank, writeback, load;
- base register number in bits 19:16;
- register list in bits 15:0.

A mode code outside the supported set emits no micro-ops. It raises an error strobe instead. The micro-ops feed a downstream issue stage, which may stall the stream by holding ready low.

Top module: `lsm_uop_seq`

## Requirements
- R1: After reset, `in_ready` is 1, and `uop_valid` and `mode_err` are 0.
- R2: An accepted supported instruction with n set list bits produces exactly n+1 micro-ops, plus one more when the writeback bit (bit 21) is 1. Only the final micro-op has `uop_last` set, and `in_ready` returns to 1 in the cycle after that micro-op is taken.
- R3: The first micro-op has kind 0 (copy). Its word is the instruction's bits 31:16 with bits 15:0 cleared, its register is the base number, and its offset is 0. It is valid in the cycle after acceptance.
- R4: Transfer micro-ops visit the set list bits from the lowest index upward. Each carries that index as its register and the instruction as its word. The kind is 1 (load) when bit 20 is 1 and 2 (store) when bit 20 is 0.
- R5: After-type modes work as follows. Codes 0x08, 0x09 and 0x0B give offsets 0, 4, … 4n-4. Codes 0x01 and 0x03 start at 4n-4 and drop by 4 per transfer down to 0.
- R6: Before-type modes work as follows. Codes 0x11 and 0x12 start at 4n and drop by 4 per transfer down to 4. Codes 0x18 and 0x19 give 4, 8, … 4n, which leaves the running pointer at 4n+4. The last transfer's offset always equals the end offset of the mode.
- R7: Any other mode code emits no micro-op. `mode_err` is 1 for exactly one cycle after acceptance, and the block stays ready.
- R8: The writeback micro-op is built from the following fields:
  - its word keeps bits 31:28 and ORs in 0x02400000;
  - the base number is placed in bits 19:16 and again in bits 15:12;
  - the value 4n is placed in the low bits;
  - its offset is 4n;
  - its kind is 3 (add) when the up bit (bit 23) is 1 and 4 (subtract) when it is 0.
- R9: While `uop_valid` is 1 and `uop_ready` is 0, all micro-op outputs are held. `in_ready` is 1 only when no micro-op is pending.
- R10: With an empty register list, the copy micro-op is followed directly by the writeback micro-op (immediate 0), or it is the last micro-op when writeback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Sequencer idle, instruction taken this cycle when valid |
| in_instr | input | 32 | Block-transfer instruction word |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Downstream takes the micro-op |
| uop_kind | output | 3 | 0 copy, 1 load, 2 store, 3 add, 4 subtract |
| uop_word | output | 32 | Encoded micro-op word |
| uop_reg | output | 4 | Register number of the micro-op |
| uop_offset | output | 7 | Byte offset from the base |
| uop_last | output | 1 | Final micro-op of the instruction |
| mode_err | output | 1 | One-cycle strobe for an unsupported mode |

## Verification
The step and end-offset assertions assume a single instruction stays resident from acceptance to its last micro-op. The holding assertion assumes downstream may stall at any point.

The stimulus offers instructions only while `in_ready` is high. It drops `in_valid` once an instruction is taken. It toggles `uop_ready` in some cases so that stalls land on copy, transfer and writeback micro-ops.

Mode codes are drawn from every supported group, plus codes outside the set. Register lists include empty, single-bit, sparse and full cases.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    UK_COPY  = 3'd0,
    UK_LOAD  = 3'd1,
    UK_STORE = 3'd2,
    UK_ADD   = 3'd3,
    UK_SUB   = 3'd4
  } uop_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_COPY = 2'd1,
    SQ_XFER = 2'd2,
    SQ_WB   = 2'd3
  } seq_state_e;

  localparam logic [31:0] WB_OPCODE = 32'h0240_0000;
endpackage

// File: rtl/lsm_mode_dec.sv
module lsm_mode_dec #(
  parameter int REGS = 16,
  parameter int CNTW = $clog2(REGS + 1),
  parameter int OFFW = $clog2(4 * REGS + 5)
) (
  input  logic [4:0]      mode,
  input  logic [REGS-1:0] list,
  output logic            supported,
  output logic [CNTW-1:0] count,
  output logic [OFFW-1:0] start_off,
  output logic [OFFW-1:0] end_off,
  output logic [OFFW-1:0] span
);
  always_comb begin
    count = '0;
    for (int i = 0; i < REGS; i++) count = count + CNTW'(list[i]);
  end

  assign span = OFFW'({count, 2'b00});

  always_comb begin
    supported = 1'b1;
    start_off = '0;
    end_off   = '0;
    case (mode)
      5'h01, 5'h03: begin start_off = span - OFFW'(4); end_off = '0; end
      5'h08, 5'h09, 5'h0B: begin start_off = '0; end_off = span - OFFW'(4); end
      5'h11, 5'h12: begin start_off = span; end_off = OFFW'(4); end
      5'h18, 5'h19: begin start_off = OFFW'(4); end_off = span; end
      default: supported = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsm_low_pick.sv
module lsm_low_pick #(
  parameter int REGS = 16,
  parameter int IDXW = $clog2(REGS)
) (
  input  logic [REGS-1:0] mask,
  output logic [IDXW-1:0] idx,
  output logic            any,
  output logic            single
);
  always_comb begin
    idx = '0;
    for (int i = REGS - 1; i >= 0; i--) if (mask[i]) idx = IDXW'(i);
  end
  assign any    = |mask;
  assign single = any && ((mask & (mask - REGS'(1))) == '0);
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
  import lsm_pkg::*;
#(
  parameter int REGS = 16,
  parameter int IDXW = $clog2(REGS),
  parameter int CNTW = $clog2(REGS + 1),
  parameter int OFFW = $clog2(4 * REGS + 5)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  output logic            uop_valid,
  input  logic            uop_ready,
  output logic [2:0]      uop_kind,
  output logic [31:0]     uop_word,
  output logic [IDXW-1:0] uop_reg,
  output logic [OFFW-1:0] uop_offset,
  output logic            uop_last,
  output logic            mode_err
);
  seq_state_e      st_q, st_d;
  logic [31:0]     instr_q, instr_d;
  logic [REGS-1:0] mask_q, mask_d;
  logic [OFFW-1:0] off_q, off_d, end_q, end_d, span_q, span_d;
  logic            err_q, err_d;

  logic            dec_sup;
  logic [CNTW-1:0] dec_cnt;
  logic [OFFW-1:0] dec_start, dec_end, dec_span;
  logic [IDXW-1:0] pick_idx;
  logic            pick_any, pick_single;

  lsm_mode_dec #(.REGS(REGS), .CNTW(CNTW), .OFFW(OFFW)) i_dec (
    .mode(in_instr[24:20]), .list(in_instr[REGS-1:0]), .supported(dec_sup),
    .count(dec_cnt), .start_off(dec_start), .end_off(dec_end), .span(dec_span)
  );

  lsm_low_pick #(.REGS(REGS), .IDXW(IDXW)) i_pick (
    .mask(mask_q), .idx(pick_idx), .any(pick_any), .single(pick_single)
  );

  logic accept, fire, up_q, wb_q, load_q;
  assign in_ready = (st_q == SQ_IDLE);
  assign accept   = in_valid && in_ready;
  assign fire     = uop_valid && uop_ready;
  assign up_q     = instr_q[23];
  assign wb_q     = instr_q[21];
  assign load_q   = instr_q[20];

  // next-state
  always_comb begin
    st_d    = st_q;
    instr_d = instr_q;
    mask_d  = mask_q;
    off_d   = off_q;
    end_d   = end_q;
    span_d  = span_q;
    err_d   = accept && !dec_sup;
    case (st_q)
      SQ_IDLE: if (accept && dec_sup) begin
        st_d    = SQ_COPY;
        instr_d = in_instr;
        mask_d  = in_instr[REGS-1:0];
        off_d   = dec_start;
        end_d   = dec_end;
        span_d  = dec_span;
      end
      SQ_COPY: if (fire) st_d = pick_any ? SQ_XFER : (wb_q ? SQ_WB : SQ_IDLE);
      SQ_XFER: if (fire) begin
        mask_d = mask_q & (mask_q - REGS'(1));
        off_d  = up_q ? off_q + OFFW'(4) : off_q - OFFW'(4);
        if (pick_single) st_d = wb_q ? SQ_WB : SQ_IDLE;
      end
      SQ_WB: if (fire) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      instr_q <= '0;
      mask_q  <= '0;
      off_q   <= '0;
      end_q   <= '0;
      span_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (accept || fire) begin
        instr_q <= instr_d;
        mask_q  <= mask_d;
        off_q   <= off_d;
        end_q   <= end_d;
        span_q  <= span_d;
      end
    end
  end

  // outputs
  uop_kind_e kind;
  always_comb begin
    uop_valid  = 1'b0;
    kind       = UK_COPY;
    uop_word   = '0;
    uop_reg    = instr_q[19:16];
    uop_offset = '0;
    uop_last   = 1'b0;
    case (st_q)
      SQ_COPY: begin
        uop_valid = 1'b1;
        uop_word  = {instr_q[31:16], 16'h0000};
        uop_last  = !pick_any && !wb_q;
      end
      SQ_XFER: begin
        uop_valid  = 1'b1;
        kind       = load_q ? UK_LOAD : UK_STORE;
        uop_word   = instr_q;
        uop_reg    = pick_idx;
        uop_offset = off_q;
        uop_last   = pick_single && !wb_q;
      end
      SQ_WB: begin
        uop_valid  = 1'b1;
        kind       = up_q ? UK_ADD : UK_SUB;
        uop_word   = {instr_q[31:28], 28'h0} | WB_OPCODE
                   | {12'h0, instr_q[19:16], instr_q[19:16], 12'h0}
                   | 32'(span_q);
        uop_offset = span_q;
        uop_last   = 1'b1;
      end
      default: ;
    endcase
  end
  assign uop_kind = kind;
  assign mode_err = err_q;

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind) && $stable(uop_word)
                                && $stable(uop_reg) && $stable(uop_offset) && $stable(uop_last));
  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !uop_valid);
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !uop_valid && in_ready);
  // R2
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready && uop_last |=> in_ready);
  // R3
  copy_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_sup |=> uop_valid && uop_kind == 3'd0);
  // R5
  step_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_XFER) && $past(fire && st_q == SQ_XFER)
    |-> uop_offset == (up_q ? $past(uop_offset) + OFFW'(4) : $past(uop_offset) - OFFW'(4)));
  // R6
  end_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_XFER) && pick_single |-> off_q == end_q);
endmodule

// File: tb/test_lsm_uop_seq.sv
module test_lsm_uop_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        uop_valid;
  logic        uop_ready = 1'b0;
  logic [2:0]  uop_kind;
  logic [31:0] uop_word;
  logic [3:0]  uop_reg;
  logic [6:0]  uop_offset;
  logic        uop_last;
  logic        mode_err;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lsm_uop_seq i_lsm_uop_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_kind(uop_kind), .uop_word(uop_word), .uop_reg(uop_reg),
    .uop_offset(uop_offset), .uop_last(uop_last), .mode_err(mode_err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] cond, input logic [4:0] mode,
                                     input logic [3:0] rn, input logic [15:0] list);
    return {cond, 3'b100, mode, rn, list};
  endfunction

  // Expected micro-op number k for instruction ins, from the requirements.
  task automatic expect_uop(input logic [31:0] ins, input int k,
                            output logic [51:0] pack, output string tag);
    logic [4:0] mode = ins[24:20];
    int n = $countones(ins[15:0]);
    int start = 0;
    int seen = 0;
    logic [2:0] kind;
    logic [31:0] word;
    logic [3:0] rg;
    int off;
    case (mode)
      5'h01, 5'h03: start = 4 * n - 4;
      5'h08, 5'h09, 5'h0B: start = 0;
      5'h11, 5'h12: start = 4 * n;
      default: start = 4;
    endcase
    rg = ins[19:16];
    if (k == 0) begin
      kind = 3'd0; word = {ins[31:16], 16'h0}; off = 0; tag = "R3";
    end else if (k <= n) begin
      kind = ins[20] ? 3'd1 : 3'd2;
      word = ins;
      for (int b = 0; b < 16; b++) begin
        if (ins[b]) begin
          seen++;
          if (seen == k) rg = 4'(b);
        end
      end
      off = ins[23] ? start + 4 * (k - 1) : start - 4 * (k - 1);
      tag = ins[24] ? "R6/R4" : "R5/R4";
    end else begin
      kind = ins[23] ? 3'd3 : 3'd4;
      word = {ins[31:28], 28'h0} | 32'h0240_0000 | {12'h0, ins[19:16], ins[19:16], 12'h0}
             | 32'(4 * n);
      off = 4 * n;
      tag = "R8";
    end
    pack = {kind, word, rg, 7'(off), 1'b0};
  endtask

  // Run one instruction; stall inserts ready-low cycles.
  task automatic run_case(input logic [31:0] ins, input bit stall);
    int n = $countones(ins[15:0]);
    int total = n + 1 + int'(ins[21]);
    int k = 0;
    int guard = 0;
    bit hold = 0;
    logic [51:0] exp_pack;
    string tag;
    @(negedge clk);
    in_instr = ins;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (k < total && guard < 200) begin
      guard++;
      expect_uop(ins, k, exp_pack, tag);
      exp_pack[0] = (k == total - 1);
      check({"R9 valid ", tag}, {63'd0, uop_valid}, 64'd1);
      check({"R9 busy ", tag}, {63'd0, in_ready}, 64'd0);
      check({tag, " R2 uop"}, {12'd0, uop_kind, uop_word, uop_reg, uop_offset, uop_last},
            {12'd0, exp_pack});
      hold = stall && !hold;
      uop_ready = !hold;
      @(negedge clk);
      if (!hold) k++;
    end
    uop_ready = 1'b0;
    check("R2 done", {62'd0, uop_valid, in_ready}, 64'd1);
  endtask

  task automatic run_bad(input logic [4:0] mode);
    @(negedge clk);
    in_instr = mk(4'hE, mode, 4'd3, 16'h00F0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 strobe", {61'd0, mode_err, uop_valid, in_ready}, 64'b101);
    @(negedge clk);
    check("R7 clear", {61'd0, mode_err, uop_valid, in_ready}, 64'b001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {61'd0, in_ready, uop_valid, mode_err}, 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {61'd0, in_ready, uop_valid, mode_err}, 64'b100);
    run_case(mk(4'hE, 5'h09, 4'd2, 16'h00F1), 0);  // R5 increment after, load
    run_case(mk(4'h1, 5'h0B, 4'd7, 16'h8421), 1);  // R5 R8 add writeback
    run_case(mk(4'h0, 5'h01, 4'd4, 16'h0006), 0);  // R5 decrement after
    run_case(mk(4'hA, 5'h03, 4'd13, 16'h00FF), 0); // R5 R8 subtract writeback
    run_case(mk(4'hE, 5'h11, 4'd5, 16'h0030), 1);  // R6 decrement before
    run_case(mk(4'h3, 5'h12, 4'd13, 16'hFFFF), 1); // R6 R4 store full list
    run_case(mk(4'hE, 5'h18, 4'd0, 16'h0101), 0);  // R6 increment before store
    run_case(mk(4'hE, 5'h19, 4'd9, 16'h8000), 1);  // R6 single register
    run_case(mk(4'hE, 5'h08, 4'd1, 16'h0000), 1);  // R10 copy only
    run_case(mk(4'h5, 5'h12, 4'd6, 16'h0000), 0);  // R10 copy then writeback
    run_bad(5'h00);                                 // R7
    run_bad(5'h1F);                                 // R7
    run_bad(5'h0A);                                 // R7
    run_case(mk(4'hE, 5'h09, 4'd8, 16'h4002), 0);  // R7 block still usable
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule